// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Flags

This block is a one-direction first-in first-out buffer of 64 words by 36 bits. A producer writes on its own clock and a consumer reads on another, and the two clocks may be unrelated or the same. A transfer happens on a rising edge of its port clock when the port is enabled, its select is low and its direction pin asks for that port's operation. A read loads a registered output on the read side.

Four active-low status flags are produced. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Each side sees the other side's pointer, passed as Gray code, only after a two-stage synchronizer. The threshold for both almost flags is one of four presets (4, 8, 16 or 32 words). A two-bit code selects the preset, and the code is captured when reset is released.

Top module: `dcFifoPreset`

## Requirements
- R1: A word is stored on a rising `wrClk` edge only when `wrEn` is 1, `wrCsN` is 0, `wrDir` is 1 (write) and `fullN` is 1. Any other combination leaves the contents unchanged.
- R2: A read happens on a rising `rdClk` edge only when `rdEn` is 1, `rdCsN` is 0, `rdDir` is 0 (read) and `emptyN` is 1. That edge loads the oldest stored word into `rdData`. Otherwise `rdData` holds its value. Words leave in the order they were written.
- R3: While `rstN` is 0, `emptyN`, `almostEmptyN` and `fullN` are 0, `almostFullN` is 1 and `rdData` is 0.
- R4: After `rstN` rises, `fullN` stays 0 through the first rising `wrClk` edge and becomes 1 after the second.
- R5: When a word is written into an empty buffer, `emptyN` is still 0 after the first rising `rdClk` edge that follows the write edge, and becomes 1 after the second.
- R6: After 64 unread words are stored, `fullN` is 0. A write attempted then is ignored: exactly the 64 stored words come out afterwards.
- R7: `almostEmptyN` is 0 when the word count seen by the read side is at or below the threshold X, and 1 above it.
- R8: `almostFullN` is 0 when the free space seen by the write side is at or below X, and 1 above it.
- R9: `offsetSel` is captured on the rising edge of `rstN` and selects X: code 00 gives 4, 01 gives 8, 10 gives 16 and 11 gives 32. Later changes of `offsetSel` have no effect until the next reset.
- R10: A read attempted while `emptyN` is 0 is ignored. `rdData` is unchanged, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| offsetSel | input | 2 | Almost-flag threshold code, captured when reset is released |
| wrEn | input | 1 | Write-port enable, active high |
| wrCsN | input | 1 | Write-port select, active low |
| wrDir | input | 1 | Write-port direction, 1 = write |
| wrData | input | 36 | Word to store |
| rdEn | input | 1 | Read-port enable, active high |
| rdCsN | input | 1 | Read-port select, active low |
| rdDir | input | 1 | Read-port direction, 0 = read |
| rdData | output | 36 | Registered read word |
| emptyN | output | 1 | Empty flag, active low, read clock |
| almostEmptyN | output | 1 | Almost-empty flag, active low, read clock |
| fullN | output | 1 | Full flag, active low, write clock |
| almostFullN | output | 1 | Almost-full flag, active low, write clock |

## Verification
Each flag has its own timing. Local pointer moves show on the flag right after the edge that made them. Moves from the other clock domain show only after two edges of the observing clock. `rdData` is valid right after the qualifying read edge. The bench drives inputs on falling edges. It samples the local effects of a transfer one time unit after the rising edge that made it. For a crossing effect, it counts the exact rising edges of the observing clock before it samples, and it waits at least three of them when only the settled value matters. The two clocks have periods that never share an edge, so the edge counts are exact.

// File: rtl/fifoPkg.sv
package fifoPkg;

  // Transfer strobes from the port controls to the storage datapath.
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } fifoStrobe_t;

endpackage

// File: rtl/syncStages.sv
module syncStages #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/fifoWrCtl.sv
module fifoWrCtl #(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = ADDR_W + 1,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [PW-1:0]     offsetVal,
  input  logic [PW-1:0]     rdGray,
  output logic              wrFire,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PW-1:0]     wrGray,
  output logic              fullN,
  output logic              almostFullN
);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rstDone;
  logic [PW-1:0] rdGraySync;
  logic [PW-1:0] rdBinSync;
  logic [PW-1:0] wrBin;
  logic [PW-1:0] wrBinNext;
  logic [PW-1:0] used;
  logic [PW-1:0] free;

  syncStages #(.W(1), .STAGES(SYNC_STAGES)) uRstSync (
    .clk(wrClk), .rstN(rstN), .d(1'b1), .q(rstDone)
  );

  syncStages #(.W(PW), .STAGES(SYNC_STAGES)) uPtrSync (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  assign rdBinSync   = grayToBin(rdGraySync);
  assign used        = wrBin - rdBinSync;
  assign free        = PW'(DEPTH) - used;
  assign fullN       = rstDone & (used != PW'(DEPTH));
  assign almostFullN = ~rstDone | (free > offsetVal);
  assign wrFire      = wrReq & fullN;
  assign wrBinNext   = wrBin + PW'(1);
  assign wrAddr      = wrBin[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrFire) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  assert_write_blocked_full_R6: assert property (
    @(posedge wrClk) disable iff (!rstN) !fullN |=> $stable(wrBin));

  assert_fill_bound_R6: assert property (
    @(posedge wrClk) disable iff (!rstDone) used <= PW'(DEPTH));

  assert_full_implies_af_R8: assert property (
    @(posedge wrClk) disable iff (!rstDone) !fullN |-> !almostFullN);

endmodule

// File: rtl/fifoRdCtl.sv
module fifoRdCtl #(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = ADDR_W + 1
) (
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [PW-1:0]     offsetVal,
  input  logic [PW-1:0]     wrGray,
  output logic              rdFire,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [PW-1:0]     rdGray,
  output logic              emptyN,
  output logic              almostEmptyN
);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rstDone;
  logic [PW-1:0] wrGraySync;
  logic [PW-1:0] wrBinSync;
  logic [PW-1:0] rdBin;
  logic [PW-1:0] rdBinNext;
  logic [PW-1:0] avail;

  syncStages #(.W(1), .STAGES(SYNC_STAGES)) uRstSync (
    .clk(rdClk), .rstN(rstN), .d(1'b1), .q(rstDone)
  );

  syncStages #(.W(PW), .STAGES(SYNC_STAGES)) uPtrSync (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign wrBinSync    = grayToBin(wrGraySync);
  assign avail        = wrBinSync - rdBin;
  assign emptyN       = rstDone & (avail != '0);
  assign almostEmptyN = rstDone & (avail > offsetVal);
  assign rdFire       = rdReq & emptyN;
  assign rdBinNext    = rdBin + PW'(1);
  assign rdAddr       = rdBin[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdFire) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assert_read_blocked_empty_R10: assert property (
    @(posedge rdClk) disable iff (!rstN) !emptyN |=> $stable(rdBin));

  assert_empty_implies_ae_R7: assert property (
    @(posedge rdClk) disable iff (!rstDone) !emptyN |-> !almostEmptyN);

endmodule

// File: rtl/fifoStore.sv
module fifoStore
  import fifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrFire) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdFire) rdData <= mem[rdAddr];
  end

  assert_rddata_hold_R2: assert property (
    @(posedge rdClk) disable iff (!rstN) !strobe.rdFire |=> $stable(rdData));

endmodule

// File: rtl/dcFifoPreset.sv
module dcFifoPreset
  import fifoPkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 6,
  parameter int BASE_OFFSET = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [1:0]        offsetSel,
  input  logic              wrEn,
  input  logic              wrCsN,
  input  logic              wrDir,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdCsN,
  input  logic              rdDir,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyN,
  output logic              almostEmptyN,
  output logic              fullN,
  output logic              almostFullN
);

  logic [1:0]        offsetCode;
  logic [PW-1:0]     offsetVal;
  logic              wrReq;
  logic              rdReq;
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [PW-1:0]     wrGray;
  logic [PW-1:0]     rdGray;

  // Threshold code is taken on the release edge of reset and held.
  always_ff @(posedge rstN) offsetCode <= offsetSel;

  assign offsetVal = PW'(BASE_OFFSET) << offsetCode;
  assign wrReq     = wrEn & ~wrCsN & wrDir;
  assign rdReq     = rdEn & ~rdCsN & ~rdDir;

  fifoWrCtl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uWrCtl (
    .wrClk(wrClk), .rstN(rstN), .wrReq(wrReq), .offsetVal(offsetVal),
    .rdGray(rdGray), .wrFire(strobe.wrFire), .wrAddr(wrAddr),
    .wrGray(wrGray), .fullN(fullN), .almostFullN(almostFullN)
  );

  fifoRdCtl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uRdCtl (
    .rdClk(rdClk), .rstN(rstN), .rdReq(rdReq), .offsetVal(offsetVal),
    .wrGray(wrGray), .rdFire(strobe.rdFire), .rdAddr(rdAddr),
    .rdGray(rdGray), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  fifoStore #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uStore (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  assert_reset_flags_R3: assert property (
    @(posedge wrClk) !rstN |-> (!fullN && almostFullN));

endmodule

// File: tb/tb_dcFifoPreset.sv
module tb_dcFifoPreset;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;

  typedef struct packed {
    logic        en;
    logic        csN;
    logic        dir;
    logic        take;
    logic [35:0] data;
  } wrVec_t;

  // R1 stimulus table: qualifiers, whether the word must be stored, data.
  localparam wrVec_t WR_TABLE [8] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 36'h0_1111_1111},
    '{1'b0, 1'b0, 1'b1, 1'b0, 36'h0_BAD0_0001},
    '{1'b1, 1'b0, 1'b1, 1'b1, 36'h9_2222_2222},
    '{1'b1, 1'b1, 1'b1, 1'b0, 36'h0_BAD0_0002},
    '{1'b1, 1'b0, 1'b1, 1'b1, 36'h3_3333_3333},
    '{1'b1, 1'b0, 1'b0, 1'b0, 36'h0_BAD0_0003},
    '{1'b1, 1'b0, 1'b1, 1'b1, 36'hF_4444_4444},
    '{1'b1, 1'b0, 1'b1, 1'b1, 36'hA_5555_5555}
  };

  logic        wrClk = 0, rdClk = 0, rstN = 0;
  logic [1:0]  offsetSel = 2'b00;
  logic        wrEn = 0, wrCsN = 1, wrDir = 1;
  logic [35:0] wrData = '0;
  logic        rdEn = 0, rdCsN = 1, rdDir = 1;
  logic [35:0] rdData;
  logic        emptyN, almostEmptyN, fullN, almostFullN;

  int checks = 0, fails = 0;
  logic [35:0] expQ [128];
  int qh = 0, qt = 0;
  logic [35:0] got;

  dcFifoPreset dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .offsetSel(offsetSel),
    .wrEn(wrEn), .wrCsN(wrCsN), .wrDir(wrDir), .wrData(wrData),
    .rdEn(rdEn), .rdCsN(rdCsN), .rdDir(rdDir), .rdData(rdData),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .fullN(fullN),
    .almostFullN(almostFullN)
  );

  always #(CLK_PERIOD / 2) wrClk = ~wrClk;
  initial begin
    #2;
    forever begin
      rdClk = 1; #(RD_PERIOD / 2);
      rdClk = 0; #(RD_PERIOD / 2);
    end
  end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrAttempt(input logic en, input logic csN, input logic dir, input logic [35:0] d);
    @(negedge wrClk);
    wrEn = en; wrCsN = csN; wrDir = dir; wrData = d;
    @(negedge wrClk);
    wrEn = 0; wrCsN = 1; wrDir = 1;
  endtask

  task automatic wrWord(input logic [35:0] d);
    wrAttempt(1'b1, 1'b0, 1'b1, d);
    expQ[qt % 128] = d; qt++;
  endtask

  task automatic rdAttempt(input logic en, input logic csN, input logic dir);
    @(negedge rdClk);
    rdEn = en; rdCsN = csN; rdDir = dir;
    @(negedge rdClk);
    rdEn = 0; rdCsN = 1; rdDir = 1;
    got = rdData;
  endtask

  task automatic popCheck(input string req);
    rdAttempt(1'b1, 1'b0, 1'b0);
    check(req, got, expQ[qh % 128]);
    qh++;
  endtask

  task automatic waitRd(input int n);
    repeat (n) @(posedge rdClk);
    #1;
  endtask

  task automatic waitWr(input int n);
    repeat (n) @(posedge wrClk);
    #1;
  endtask

  task automatic doReset(input logic [1:0] sel);
    @(negedge wrClk);
    rstN = 0; offsetSel = sel;
    repeat (6) @(posedge rdClk);
    @(negedge wrClk);
    #1 rstN = 1;
    waitWr(3);
    offsetSel = ~sel;   // R9: must not matter after release
    waitRd(4);
    qh = 0; qt = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    // R3: state held in reset
    repeat (6) @(posedge rdClk);
    #1;
    check("R3 emptyN", emptyN, 0);
    check("R3 almostEmptyN", almostEmptyN, 0);
    check("R3 fullN", fullN, 0);
    check("R3 almostFullN", almostFullN, 1);
    check("R3 rdData", rdData, 0);

    // R4: full release two write edges after reset
    @(negedge wrClk);
    #1 rstN = 1;
    @(posedge wrClk); #1;
    check("R4 fullN after 1st edge", fullN, 0);
    @(posedge wrClk); #1;
    check("R4 fullN after 2nd edge", fullN, 1);
    offsetSel = 2'b11;  // R9: captured code 00 must stay in force
    waitRd(4);

    // R5: empty release two read edges after a write
    @(negedge wrClk);
    wrEn = 1; wrCsN = 0; wrDir = 1; wrData = 36'h0_0000_00A5;
    @(posedge wrClk);
    wrEn <= 0; wrCsN <= 1;
    expQ[qt] = 36'h0_0000_00A5; qt++;
    @(posedge rdClk); #1;
    check("R5 emptyN after 1st read edge", emptyN, 0);
    @(posedge rdClk); #1;
    check("R5 emptyN after 2nd read edge", emptyN, 1);
    check("R7 almostEmptyN one word", almostEmptyN, 0);

    // R1: table of write attempts
    for (int i = 0; i < 8; i++) begin
      wrAttempt(WR_TABLE[i].en, WR_TABLE[i].csN, WR_TABLE[i].dir, WR_TABLE[i].data);
      if (WR_TABLE[i].take) begin
        expQ[qt] = WR_TABLE[i].data; qt++;
      end
    end
    waitRd(3);
    check("R7 almostEmptyN six words X=4", almostEmptyN, 1);
    check("R8 almostFullN 58 free", almostFullN, 1);

    // R2 and R7 boundary while draining
    popCheck("R2 first word");
    check("R7 almostEmptyN five words", almostEmptyN, 1);
    rdAttempt(1'b0, 1'b0, 1'b0);
    check("R2 no read en low", got, 36'h0_0000_00A5);
    rdAttempt(1'b1, 1'b1, 1'b0);
    check("R2 no read cs high", got, 36'h0_0000_00A5);
    rdAttempt(1'b1, 1'b0, 1'b1);
    check("R2 no read dir write", got, 36'h0_0000_00A5);
    popCheck("R1 R2 table word 0");
    check("R7 almostEmptyN four words X=4", almostEmptyN, 0);
    for (int i = 0; i < 4; i++) popCheck("R1 R2 table order");
    check("R2 emptyN after drain", emptyN, 0);

    // R10: read while empty
    rdAttempt(1'b1, 1'b0, 1'b0);
    check("R10 rdData unchanged", got, 36'hA_5555_5555);
    wrWord(36'h7_7777_0001);
    waitRd(3);
    popCheck("R10 next word after empty read");

    // R8 and R6: fill to full
    waitWr(4);
    for (int i = 0; i < 64; i++) begin
      wrWord(36'h1_0000_0100 + 36'(i));
      if (i == 58) check("R8 almostFullN 5 free", almostFullN, 1);
      if (i == 59) check("R8 almostFullN 4 free", almostFullN, 0);
      if (i == 62) check("R6 fullN 1 free", fullN, 1);
    end
    check("R6 fullN at 64", fullN, 0);
    wrAttempt(1'b1, 1'b0, 1'b1, 36'h0_DEAD_BEEF);
    waitRd(3);
    for (int i = 0; i < 64; i++) popCheck("R6 R2 full drain");
    check("R6 empty after 64 (extra write dropped)", emptyN, 0);

    // R9: code 11 gives X=32
    doReset(2'b11);
    for (int i = 0; i < 31; i++) wrWord(36'h2_0000_0000 + 36'(i));
    check("R9 R8 almostFullN 33 free X=32", almostFullN, 1);
    wrWord(36'h2_0000_001F);
    check("R9 R8 almostFullN 32 free X=32", almostFullN, 0);
    wrWord(36'h2_0000_0020);
    waitRd(3);
    check("R9 R7 almostEmptyN 33 words X=32", almostEmptyN, 1);
    popCheck("R9 first word after reset");
    check("R9 R7 almostEmptyN 32 words X=32", almostEmptyN, 0);

    // R9: code 01 gives X=8
    doReset(2'b01);
    for (int i = 0; i < 8; i++) wrWord(36'h3_0000_0000 + 36'(i));
    waitRd(3);
    check("R9 R7 almostEmptyN 8 words X=8", almostEmptyN, 0);
    wrWord(36'h3_0000_0008);
    waitRd(3);
    check("R9 R7 almostEmptyN 9 words X=8", almostEmptyN, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule